// File: doc/BRIEF.md
# Transmit synthesizer divider and lock logic

This block is the digital half of a transmit IF frequency synthesizer. It divides a reference clock and a VCO-derived feedback clock down to a common comparison rate and compares the two divided edges in a two-flip-flop phase-frequency detector. The detector's up and down pulses steer an external analog charge pump. Both incoming clocks are treated as level signals and sampled in a fast system clock domain, so their rates must stay well below half the system clock.

An acquisition controller selects the charge pump's high current level, which is eleven times the low level, whenever the operating mode moves into a transmit-active state. It falls back to low current once the loop is declared locked. Lock is declared after a run of consecutive comparison periods whose pulse width stays at or below a programmable threshold. Any period above the threshold drops the lock again. The lock output behaves like an open-drain pin: it is driven low only while the loop transmits, lock detection is enabled and no lock is held. In all other cases it is released.

With the default parameters, the 19.68 MHz reference is divided by 16 to a 1.23 MHz comparison rate, the feedback clock is divided by 106, and 32 good periods declare lock.

Top module: `txsyn_lock_top`

## Requirements
- R1: Each divider emits exactly one comparison event per REF_DIV (reference) or FB_DIV (feedback) sampled rising edges. In a transmit mode, a period with exactly that many edges on each input yields exactly one cycle in which both pump outputs are high.
- R2: If the feedback event trails the reference event by d system clocks, pump_up_o alone is high for d cycles. If the feedback event leads by d, pump_dn_o alone is high for d cycles. Both are high together for exactly one cycle and then both clear on the next edge.
- R3: mode_i encoding: 2'b00 sleep, 2'b01 idle, 2'b10 CDMA transmit/receive, 2'b11 FM transmit/receive. A mode is transmit-active when bit 1 is set. Outside transmit-active modes, both pump outputs and hi_cur_o are low and the divider and lock state is cleared.
- R4: hi_cur_o rises one clock after mode_i changes to a different value with bit 1 set. This includes a change between the two transmit modes. It never rises at any other time.
- R5: A period is good when its one-sided pulse width is at most thresh_i. After LOCK_PERIODS consecutive good periods, lock is declared and hi_cur_o falls on the following clock.
- R6: A period whose width exceeds thresh_i clears the good-period count and the lock at once, and does not raise hi_cur_o again.
- R7: lock_o is 0 only while the mode is transmit-active, det_en_i is 1 and no lock is held. Otherwise it is 1 (released).
- R8: When a change into a transmit mode is sampled on the same edge as the period that would declare lock, the restart wins: hi_cur_o stays high, no lock is declared, and a further LOCK_PERIODS good periods are needed.
- R9: During reset, pump_up_o, pump_dn_o and hi_cur_o are 0. The stored mode is sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | 1 | Reference clock level, sampled |
| fb_clk_i | input | 1 | VCO-derived feedback clock level, sampled |
| mode_i | input | 2 | Operating mode (encoding in R3) |
| det_en_i | input | 1 | Enables unlocked indication on lock_o |
| thresh_i | input | WIDTH_W | Maximum good pulse width in system clocks |
| pump_up_o | output | 1 | Charge pump up pulse |
| pump_dn_o | output | 1 | Charge pump down pulse |
| hi_cur_o | output | 1 | 1 selects the high acquisition current |
| lock_o | output | 1 | 0 drives the lock pin low, 1 releases it |

## Verification
The lock declaration and an acquisition restart can fall on the same clock edge, because a mode change between the two transmit modes does not stop the dividers. The bench provokes this by first collecting LOCK_PERIODS-1 good periods. It then switches CDMA to FM on exactly the edge that samples the final period's coincident up/down cycle, which lies three system clocks after that period's last input edges. It judges the outcome by requiring hi_cur_o high and lock_o low afterwards, and by requiring that lock appears only after a full new run of good periods and not one period earlier.

// File: rtl/txsyn_pkg.sv
package txsyn_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP = 2'b00,
    MODE_IDLE  = 2'b01,
    MODE_CDMA  = 2'b10,
    MODE_FM    = 2'b11
  } mode_e;

  function automatic logic is_tx(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/txsyn_div.sv
module txsyn_div #(
  parameter int DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic lvl_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [1:0]    sync_q;
  logic          prev_q;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise   = sync_q[1] & ~prev_q;
  assign tick_o = rise && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], lvl_i};
      prev_q <= sync_q[1];
      if (clr_i)     cnt_q <= '0;
      else if (rise) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/txsyn_pfd.sv
module txsyn_pfd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ref_tick_i,
  input  logic fb_tick_i,
  output logic up_o,
  output logic dn_o
);
  logic up_q, dn_q;

  assign up_o = up_q;
  assign dn_o = dn_q;

  // coincident state resets both; ticks arriving in that cycle are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (clr_i || (up_q && dn_q)) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_q | ref_tick_i;
      dn_q <= dn_q | fb_tick_i;
    end
  end
endmodule

// File: rtl/txsyn_lock_mon.sv
module txsyn_lock_mon #(
  parameter int LOCK_PERIODS = 32,
  parameter int WIDTH_W      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               up_i,
  input  logic               dn_i,
  input  logic [WIDTH_W-1:0] thresh_i,
  output logic               locked_o,
  output logic               bad_o
);
  localparam int LCW = $clog2(LOCK_PERIODS + 1);
  localparam logic [LCW-1:0] FULL = LCW'(LOCK_PERIODS);
  localparam logic [LCW-1:0] LAST = LCW'(LOCK_PERIODS - 1);

  logic [WIDTH_W-1:0] wid_q;
  logic [LCW-1:0]     cnt_q;
  logic               locked_q;
  logic               pulse, both, good, bad;

  always_comb begin
    pulse = up_i ^ dn_i;
    both  = up_i & dn_i;
    bad   = pulse && (wid_q >= thresh_i);
    good  = both && (wid_q <= thresh_i);
  end

  assign locked_o = locked_q;
  assign bad_o    = bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wid_q    <= '0;
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      if (clr_i || both)                wid_q <= '0;
      else if (pulse && (wid_q != '1))  wid_q <= wid_q + WIDTH_W'(1);

      if (clr_i || bad) begin
        cnt_q    <= '0;
        locked_q <= 1'b0;
      end else if (good) begin
        if (cnt_q != FULL) cnt_q <= cnt_q + LCW'(1);
        if (cnt_q == LAST) locked_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/txsyn_lock_top.sv
module txsyn_lock_top
  import txsyn_pkg::*;
#(
  parameter int REF_DIV      = 16,
  parameter int FB_DIV       = 106,
  parameter int LOCK_PERIODS = 32,
  parameter int WIDTH_W      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_clk_i,
  input  logic               fb_clk_i,
  input  logic [1:0]         mode_i,
  input  logic               det_en_i,
  input  logic [WIDTH_W-1:0] thresh_i,
  output logic               pump_up_o,
  output logic               pump_dn_o,
  output logic               hi_cur_o,
  output logic               lock_o
);
  localparam int NPATH = 2;

  logic [1:0]       mode_q;
  logic             tx_act, acq_start, acq_q;
  logic             locked, bad;
  logic [NPATH-1:0] lvl, tick;

  assign tx_act    = is_tx(mode_i);
  assign acq_start = tx_act && (mode_i != mode_q);
  assign lvl       = {fb_clk_i, ref_clk_i};

  // path 0 reference, path 1 feedback
  for (genvar g = 0; g < NPATH; g++) begin : g_div
    localparam int DIV_G = (g == 0) ? REF_DIV : FB_DIV;
    txsyn_div #(.DIV(DIV_G)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (!tx_act),
      .lvl_i  (lvl[g]),
      .tick_o (tick[g])
    );
  end

  txsyn_pfd u_pfd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (!tx_act),
    .ref_tick_i (tick[0]),
    .fb_tick_i  (tick[1]),
    .up_o       (pump_up_o),
    .dn_o       (pump_dn_o)
  );

  txsyn_lock_mon #(
    .LOCK_PERIODS (LOCK_PERIODS),
    .WIDTH_W      (WIDTH_W)
  ) u_mon (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!tx_act || acq_start),
    .up_i     (pump_up_o),
    .dn_i     (pump_dn_o),
    .thresh_i (thresh_i),
    .locked_o (locked),
    .bad_o    (bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SLEEP;
      acq_q  <= 1'b0;
    end else begin
      mode_q <= mode_i;
      if (!tx_act)        acq_q <= 1'b0;
      else if (acq_start) acq_q <= 1'b1;
      else if (locked)    acq_q <= 1'b0;
    end
  end

  assign hi_cur_o = acq_q;
  assign lock_o   = !(tx_act && det_en_i && !locked);
endmodule

// File: rtl/txsyn_chk.sv
module txsyn_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       det_en_i,
  input logic       pump_up_o,
  input logic       pump_dn_o,
  input logic       hi_cur_o,
  input logic       lock_o,
  input logic [1:0] mode_q,
  input logic       locked,
  input logic       bad
);
  // R2
  pfd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pump_up_o && pump_dn_o) |=> (!pump_up_o && !pump_dn_o));

  // R3
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(mode_i[1]) |-> (!pump_up_o && !pump_dn_o && !hi_cur_o));

  // R4
  acq_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_cur_o) |-> ($past(mode_i[1]) && ($past(mode_i) != $past(mode_q))));

  // R5
  acq_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hi_cur_o) |-> ($past(locked) || !$past(mode_i[1])));

  // R6
  bad_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> !locked);

  // R7
  lock_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_o |-> (mode_i[1] && det_en_i));
endmodule

bind txsyn_lock_top txsyn_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .det_en_i  (det_en_i),
  .pump_up_o (pump_up_o),
  .pump_dn_o (pump_dn_o),
  .hi_cur_o  (hi_cur_o),
  .lock_o    (lock_o),
  .mode_q    (mode_q),
  .locked    (locked),
  .bad       (bad)
);

// File: tb/txsyn_lock_top_tb_top.sv
module txsyn_lock_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RD   = 4;
  localparam int FD   = 6;
  localparam int LP   = 32;
  localparam int WW   = 8;
  localparam int PLEN = 40;
  localparam int BASE = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_clk = 1'b0;
  logic          fb_clk = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          det_en = 1'b1;
  logic [WW-1:0] thresh = 8'd3;
  logic          pu, pd, hi, lk;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txsyn_lock_top #(
    .REF_DIV(RD), .FB_DIV(FD), .LOCK_PERIODS(LP), .WIDTH_W(WW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .fb_clk_i(fb_clk),
    .mode_i(mode), .det_en_i(det_en), .thresh_i(thresh),
    .pump_up_o(pu), .pump_dn_o(pd), .hi_cur_o(hi), .lock_o(lk)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one comparison period: RD reference and FD feedback rises, last ones lag apart
  task automatic run_period(input int lag, input int sw_c, input logic [1:0] sw_m,
                            input bit exp_tx);
    int nu = 0, nd = 0, nb = 0;
    for (int c = 0; c < PLEN; c++) begin
      logic r, f;
      @(negedge clk);
      if (pu && !pd) nu++;
      if (pd && !pu) nd++;
      if (pu && pd)  nb++;
      if (c == sw_c) mode = sw_m;
      r = 1'b0;
      f = 1'b0;
      for (int j = 0; j < RD; j++) if (c == BASE - 2*(RD-1-j)) r = 1'b1;
      for (int j = 0; j < FD; j++) if (c == BASE + lag - 2*(FD-1-j)) f = 1'b1;
      ref_clk = r;
      fb_clk  = f;
    end
    chk("R2", "up-only cycles", nu, exp_tx ? ((lag > 0) ? lag : 0) : 0);
    chk("R2", "down-only cycles", nd, exp_tx ? ((lag < 0) ? -lag : 0) : 0);
    chk("R1", "coincident cycles", nb, exp_tx ? 1 : 0);
  endtask

  task automatic relock(input string req);
    for (int k = 0; k < LP; k++) begin
      run_period(0, -1, 2'b00, 1'b1);
      if (k == LP-2) chk(req, "lock before last good period", int'(lk), 0);
    end
    chk(req, "lock after full run", int'(lk), 1);
    chk(req, "low current after lock", int'(hi), 0);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9", "pump up in reset", int'(pu), 0);
    chk("R9", "pump down in reset", int'(pd), 0);
    chk("R9", "high current in reset", int'(hi), 0);
    chk("R9", "lock released in reset", int'(lk), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 / R7: sleep and idle ignore clocks
    run_period(2, -1, 2'b00, 1'b0);
    chk("R3", "sleep high current", int'(hi), 0);
    chk("R7", "sleep lock released", int'(lk), 1);
    @(negedge clk);
    mode = 2'b01;
    run_period(-2, -1, 2'b00, 1'b0);
    chk("R3", "idle high current", int'(hi), 0);
    chk("R7", "idle lock released", int'(lk), 1);

    // R4 entry into CDMA
    @(negedge clk);
    mode = 2'b10;
    @(negedge clk);
    chk("R4", "acquisition on entry", int'(hi), 1);
    chk("R7", "lock low while acquiring", int'(lk), 0);

    // R5 lock over a sweep of lags within threshold
    for (int k = 0; k < LP; k++) begin
      run_period((k % 7) - 3, -1, 2'b00, 1'b1);
      chk("R5", "lock state in run", int'(lk), (k == LP-1) ? 1 : 0);
      chk("R5", "current select in run", int'(hi), (k == LP-1) ? 0 : 1);
    end

    // R5 / R6 threshold edge at 3
    run_period(3, -1, 2'b00, 1'b1);
    chk("R5", "width equal to threshold keeps lock", int'(lk), 1);
    run_period(-4, -1, 2'b00, 1'b1);
    chk("R6", "width over threshold drops lock", int'(lk), 0);
    chk("R6", "no reacquisition on bad period", int'(hi), 0);

    // R7 detection disabled
    @(negedge clk);
    det_en = 1'b0;
    @(negedge clk);
    chk("R7", "released with detection off", int'(lk), 1);
    det_en = 1'b1;
    @(negedge clk);
    chk("R7", "low again with detection on", int'(lk), 0);
    relock("R6");

    // R5 / R6 threshold sweep
    for (int th = 0; th < 3; th++) begin
      thresh = WW'(th);
      run_period(th, -1, 2'b00, 1'b1);
      chk("R5", "lag at threshold", int'(lk), 1);
      run_period(-(th + 1), -1, 2'b00, 1'b1);
      chk("R6", "lag one over threshold", int'(lk), 0);
      relock("R6");
    end
    thresh = 8'd3;

    // R4 transmit to transmit change restarts acquisition
    @(negedge clk);
    mode = 2'b11;
    @(negedge clk);
    chk("R4", "acquisition on CDMA to FM", int'(hi), 1);
    chk("R4", "lock dropped on restart", int'(lk), 0);
    relock("R5");

    // R8 restart on the same edge as lock declaration
    run_period(6, -1, 2'b00, 1'b1);
    chk("R6", "unlock before collision", int'(lk), 0);
    for (int k = 0; k < LP-1; k++) run_period(0, -1, 2'b00, 1'b1);
    chk("R8", "still unlocked before final period", int'(lk), 0);
    run_period(0, BASE + 3, 2'b10, 1'b1);
    chk("R8", "restart wins over lock", int'(lk), 0);
    chk("R8", "high current after collision", int'(hi), 1);
    relock("R8");

    // R3 back to idle
    @(negedge clk);
    mode = 2'b01;
    @(negedge clk);
    chk("R7", "idle releases lock", int'(lk), 1);
    run_period(1, -1, 2'b00, 1'b0);
    chk("R3", "idle after transmit", int'(hi), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule